// File: doc/BRIEF.md
# Timestamp Capture Bank

This block freezes a copy of a free-running 64-bit nanosecond time value whenever a timestamp event happens. It holds four receive slots chosen by a slot index that comes with each receive strobe, one transmit slot, and one slot fed by an external trigger pin. Software reads each capture as two 32-bit words through a small register port, and sees which slots hold unread captures in a status word.

A slot that holds a capture is locked. Any further strobe aimed at it is thrown away and counted in a dropped-capture counter. Reading the upper word of a slot unlocks it. The external pin passes through a two-flop synchronizer, and a two-bit control field picks which of its edges fire a capture. A transmit interrupt output stays high while the transmit slot is locked and the interrupt enable bit is set.

Top module: `tsl_bank`

## Requirements
- R1: After reset every slot is unlocked, the status word (address 1) and the dropped count (address 2) read 0, `txIrq` is 0, and the control word (address 0) reads 0x0001_0000: interrupt enable is bit 0 = 0, and the edge field is bits 17:16 = 01.
- R2: A receive strobe at a clock edge, aimed at an unlocked slot `rxSlot` k, stores the `timeNow` present at that edge. It sets status bit k. Slot k reads at address 4+2k (bits 31:0) and 5+2k (bits 63:32).
- R3: A strobe aimed at a slot that is already locked at that edge leaves the stored value and the lock unchanged. This holds even if the same edge unlocks the slot. The 16-bit counter at address 2 rises by one for every strobe dropped this way, on any slot.
- R4: Reading a slot's upper word clears its status bit, so the next strobe can capture. Reading the lower word leaves the lock in place.
- R5: A transmit strobe captures into the transmit slot (addresses 12 and 13, status bit 4) under the same lock and unlock rules.
- R6: `txIrq` is high exactly while the transmit slot is locked and control bit 0 is 1.
- R7: The edge field (control bits 17:16) chooses the pin edge: 00 none, 01 rising, 10 falling, 11 both. A chosen edge captures into the pin slot (addresses 14 and 15, status bit 5), two clock edges after the edge that first samples the new pin level. It uses the `timeNow` of that edge and follows the same lock rules.
- R8: Read data is registered. It shows the addressed word one cycle after `regRead` and is 0 in any cycle that follows no read, or a read of an unmapped address. A write to address 0 updates bits 0 and 17:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| timeNow | input | 64 | Running time value |
| rxStrobe | input | 1 | Receive capture request |
| rxSlot | input | 2 | Receive slot targeted by the request |
| txStrobe | input | 1 | Transmit capture request |
| auxPin | input | 1 | Asynchronous external trigger |
| regRead | input | 1 | Register read request |
| regWrite | input | 1 | Register write request |
| regAddr | input | 5 | Word address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Registered read data |
| txIrq | output | 1 | Transmit capture interrupt |

## Verification
Each result has a fixed latency:
- Status bits, stored values and the dropped count take effect at the clock edge that sees the strobe.
- `txIrq` follows at that same edge.
- Read data shows up one cycle after the read request.
- A pin transition reaches the capture logic two edges after it is first sampled.

The bench drives inputs on falling edges and steps a behavioural reference model on each rising edge. The model uses a pin-history queue in place of the synchronizer. It compares `regRdata` and `txIrq` with the model on every falling edge, after all of these delays have settled.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  parameter int RX_SLOTS = 4;
  localparam int RX_IDX_W = $clog2(RX_SLOTS);
  localparam int SLOT_CNT = RX_SLOTS + 2;
  localparam int TX_IDX   = RX_SLOTS;
  localparam int AUX_IDX  = RX_SLOTS + 1;
  localparam int INC_W    = $clog2(SLOT_CNT + 1);

  localparam int ADR_CTRL  = 0;
  localparam int ADR_STAT  = 1;
  localparam int ADR_DROP  = 2;
  localparam int ADR_SLOT0 = 4;

  localparam int IRQ_EN_BIT = 0;
  localparam int EDGE_LSB   = 16;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [SLOT_CNT-1:0] capture;   // load slot with current time
    logic [SLOT_CNT-1:0] release_;  // slot unlocked this cycle
  } capStrb_t;
endpackage

// File: rtl/tsl_ctrl.sv
module tsl_ctrl
  import tsl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int DROP_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxStrobe,
  input  logic [RX_IDX_W-1:0] rxSlot,
  input  logic                txStrobe,
  input  logic                auxPin,
  input  logic                regRead,
  input  logic                regWrite,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  output capStrb_t            strb,
  output logic [SLOT_CNT-1:0] validWord,
  output logic [DATA_W-1:0]   ctrlWord,
  output logic [DROP_W-1:0]   dropCount,
  output logic                txIrq
);
  logic  auxMeta, auxSync, auxPrev;
  logic  irqEn;
  edge_t edgeSel;
  logic  auxFire;
  logic [SLOT_CNT-1:0] reqVec, relVec, capVec, dropVec;
  logic [INC_W-1:0]    dropInc;

  // two-flop synchronizer plus history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      auxMeta <= 1'b0;
      auxSync <= 1'b0;
      auxPrev <= 1'b0;
    end else begin
      auxMeta <= auxPin;
      auxSync <= auxMeta;
      auxPrev <= auxSync;
    end
  end

  always_comb begin
    unique case (edgeSel)
      EDGE_RISE: auxFire = auxSync & ~auxPrev;
      EDGE_FALL: auxFire = ~auxSync & auxPrev;
      EDGE_BOTH: auxFire = auxSync ^ auxPrev;
      default:   auxFire = 1'b0;
    endcase
  end

  // per-slot request and unlock decode
  for (genvar k = 0; k < SLOT_CNT; k++) begin : g_slot
    if (k < RX_SLOTS) begin : g_rx
      assign reqVec[k] = rxStrobe && (rxSlot == RX_IDX_W'(k));
    end else if (k == TX_IDX) begin : g_tx
      assign reqVec[k] = txStrobe;
    end else begin : g_aux
      assign reqVec[k] = auxFire;
    end
    assign relVec[k] = regRead && (regAddr == ADDR_W'(ADR_SLOT0 + 2 * k + 1));
  end

  assign capVec  = reqVec & ~validWord;
  assign dropVec = reqVec & validWord;

  always_comb begin
    dropInc = '0;
    for (int k = 0; k < SLOT_CNT; k++) dropInc = dropInc + INC_W'(dropVec[k]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validWord <= '0;
      dropCount <= '0;
      irqEn     <= 1'b0;
      edgeSel   <= EDGE_RISE;
    end else begin
      validWord <= (validWord & ~relVec) | capVec;
      dropCount <= dropCount + DROP_W'(dropInc);
      if (regWrite && regAddr == ADDR_W'(ADR_CTRL)) begin
        irqEn   <= regWdata[IRQ_EN_BIT];
        edgeSel <= edge_t'(regWdata[EDGE_LSB+1:EDGE_LSB]);
      end
    end
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[IRQ_EN_BIT] = irqEn;
    ctrlWord[EDGE_LSB+1:EDGE_LSB] = edgeSel;
  end

  assign strb.capture  = capVec;
  assign strb.release_ = relVec;
  assign txIrq = irqEn & validWord[TX_IDX];
endmodule

// File: rtl/tsl_datapath.sv
module tsl_datapath
  import tsl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int DROP_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2*DATA_W-1:0] timeNow,
  input  capStrb_t            strb,
  input  logic [SLOT_CNT-1:0] validWord,
  input  logic [DATA_W-1:0]   ctrlWord,
  input  logic [DROP_W-1:0]   dropCount,
  input  logic                regRead,
  input  logic [ADDR_W-1:0]   regAddr,
  output logic [DATA_W-1:0]   regRdata
);
  localparam int TIME_W = 2 * DATA_W;

  logic [TIME_W-1:0] slotTime [SLOT_CNT];
  logic [DATA_W-1:0] rdNext;

  for (genvar k = 0; k < SLOT_CNT; k++) begin : g_store
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) slotTime[k] <= '0;
      else if (strb.capture[k]) slotTime[k] <= timeNow;
    end
  end

  always_comb begin
    rdNext = '0;
    if (regAddr == ADDR_W'(ADR_CTRL)) rdNext = ctrlWord;
    if (regAddr == ADDR_W'(ADR_STAT)) rdNext = DATA_W'(validWord);
    if (regAddr == ADDR_W'(ADR_DROP)) rdNext = DATA_W'(dropCount);
    for (int k = 0; k < SLOT_CNT; k++) begin
      if (regAddr == ADDR_W'(ADR_SLOT0 + 2 * k))     rdNext = slotTime[k][DATA_W-1:0];
      if (regAddr == ADDR_W'(ADR_SLOT0 + 2 * k + 1)) rdNext = slotTime[k][TIME_W-1:DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regRdata <= '0;
    else       regRdata <= regRead ? rdNext : '0;
  end
endmodule

// File: rtl/tsl_bank.sv
module tsl_bank
  import tsl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int DROP_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2*DATA_W-1:0] timeNow,
  input  logic                rxStrobe,
  input  logic [RX_IDX_W-1:0] rxSlot,
  input  logic                txStrobe,
  input  logic                auxPin,
  input  logic                regRead,
  input  logic                regWrite,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  output logic                txIrq
);
  capStrb_t            strb;
  logic [SLOT_CNT-1:0] validWord;
  logic [DATA_W-1:0]   ctrlWord;
  logic [DROP_W-1:0]   dropCount;

  tsl_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DROP_W(DROP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxStrobe(rxStrobe), .rxSlot(rxSlot),
    .txStrobe(txStrobe), .auxPin(auxPin), .regRead(regRead),
    .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .strb(strb), .validWord(validWord), .ctrlWord(ctrlWord),
    .dropCount(dropCount), .txIrq(txIrq)
  );

  tsl_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DROP_W(DROP_W)) u_dp (
    .clk(clk), .rstN(rstN), .timeNow(timeNow), .strb(strb),
    .validWord(validWord), .ctrlWord(ctrlWord), .dropCount(dropCount),
    .regRead(regRead), .regAddr(regAddr), .regRdata(regRdata)
  );
endmodule

// File: rtl/tsl_bank_chk.sv
module tsl_bank_chk
  import tsl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic                rxStrobe,
  input logic [RX_IDX_W-1:0] rxSlot,
  input logic                regRead,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [DATA_W-1:0]   regRdata,
  input logic                txIrq,
  input logic [SLOT_CNT-1:0] validWord,
  input logic                irqEn
);
  localparam logic [ADDR_W-1:0] TX_HI = ADDR_W'(ADR_SLOT0 + 2 * TX_IDX + 1);

  // R2: a strobe to a free slot locks it
  a_r2_capture_locks: assert property (@(posedge clk) disable iff (!rstN)
    (rxStrobe && !validWord[rxSlot]) |=> validWord[$past(rxSlot)]);

  for (genvar k = 0; k < RX_SLOTS; k++) begin : g_rx
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(ADR_SLOT0 + 2 * k + 1);
    // R3: a locked slot stays locked until its upper word is read
    a_r3_lock_holds: assert property (@(posedge clk) disable iff (!rstN)
      (validWord[k] && !(regRead && regAddr == HI)) |=> validWord[k]);
    // R4: reading the upper word unlocks the slot
    a_r4_high_read_unlocks: assert property (@(posedge clk) disable iff (!rstN)
      (validWord[k] && regRead && regAddr == HI) |=> !validWord[k]);
  end

  // R5: transmit slot unlocks on its upper-word read
  a_r5_tx_unlocks: assert property (@(posedge clk) disable iff (!rstN)
    (validWord[TX_IDX] && regRead && regAddr == TX_HI) |=> !validWord[TX_IDX]);

  // R6: interrupt only with a locked transmit slot and enable set, and always then
  a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> (validWord[TX_IDX] && irqEn));
  a_r6_irq_raised: assert property (@(posedge clk) disable iff (!rstN)
    (validWord[TX_IDX] && irqEn) |-> txIrq);

  // R8: no read request, no read data
  a_r8_idle_rdata: assert property (@(posedge clk) disable iff (!rstN)
    !regRead |=> (regRdata == '0));
endmodule

bind tsl_bank tsl_bank_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .rxStrobe(rxStrobe), .rxSlot(rxSlot),
  .regRead(regRead), .regAddr(regAddr), .regRdata(regRdata), .txIrq(txIrq),
  .validWord(validWord), .irqEn(ctrlWord[tsl_pkg::IRQ_EN_BIT])
);

// File: tb/tsl_bank_bench.sv
`timescale 1ns/1ps
module tsl_bank_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] timeNow = 64'h0000_0002_FFFF_FF80;
  logic        rxStrobe = 1'b0;
  logic [1:0]  rxSlot = 2'd0;
  logic        txStrobe = 1'b0;
  logic        auxPin = 1'b0;
  logic        regRead = 1'b0;
  logic        regWrite = 1'b0;
  logic [4:0]  regAddr = 5'd0;
  logic [31:0] regWdata = 32'd0;
  logic [31:0] regRdata;
  logic        txIrq;

  always #4 clk = ~clk; // 125 MHz

  tsl_bank u_tsl_bank (
    .clk(clk), .rstN(rstN), .timeNow(timeNow), .rxStrobe(rxStrobe),
    .rxSlot(rxSlot), .txStrobe(txStrobe), .auxPin(auxPin),
    .regRead(regRead), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .txIrq(txIrq)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit compareOn = 1'b0;

  // ---------------- reference model ----------------
  longint unsigned slotVal [6];
  bit [5:0]  vld;
  int unsigned drop;
  bit        irqEnM;
  bit [1:0]  edgeM;
  bit        hist [$];
  bit [31:0] expRdata;
  bit        expIrq;
  string     expTag = "R8";

  function automatic string tagOf(input int a);
    if (a == 0) return "R8";
    if (a == 1) return "R2";
    if (a == 2) return "R3";
    if (a >= 4 && a <= 11) return "R2";
    if (a == 12 || a == 13) return "R5";
    if (a == 14 || a == 15) return "R7";
    return "R8";
  endfunction

  function automatic bit [31:0] modelRead(input int a);
    if (a == 0) return {14'd0, edgeM, 15'd0, irqEnM};
    if (a == 1) return {26'd0, vld};
    if (a == 2) return drop[31:0];
    if (a >= 4 && a <= 15) begin
      if (a % 2 == 0) return slotVal[(a - 4) / 2][31:0];
      return slotVal[(a - 4) / 2][63:32];
    end
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (slotVal[i]) slotVal[i] = 0;
      vld = 0; drop = 0; irqEnM = 0; edgeM = 2'b01;
      hist = '{1'b0, 1'b0, 1'b0};
      expRdata = 0; expTag = "R1";
    end else begin
      bit [5:0] req, rel, cap;
      bit rise, fall, fire;
      req = 0; rel = 0; cap = 0;
      expRdata = regRead ? modelRead(regAddr) : 32'd0;
      expTag = tagOf(regAddr);
      if (rxStrobe) req[rxSlot] = 1'b1;
      req[4] = txStrobe;
      rise = hist[1] && !hist[2];
      fall = !hist[1] && hist[2];
      fire = (edgeM == 2'b01 && rise) || (edgeM == 2'b10 && fall) ||
             (edgeM == 2'b11 && (rise || fall));
      req[5] = fire;
      if (regRead && regAddr >= 5 && regAddr <= 15 && regAddr % 2 == 1)
        rel[(regAddr - 4) / 2] = 1'b1;
      for (int k = 0; k < 6; k++) begin
        if (req[k]) begin
          if (vld[k]) drop = (drop + 1) % 65536;
          else begin slotVal[k] = timeNow; cap[k] = 1'b1; end
        end
      end
      vld = (vld & ~rel) | cap;
      if (regWrite && regAddr == 0) begin
        irqEnM = regWdata[0];
        edgeM  = regWdata[17:16];
      end
      hist.push_front(auxPin);
      void'(hist.pop_back());
    end
    expIrq = vld[4] && irqEnM;
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (compareOn && !done) begin
      checks++;
      if (regRdata !== expRdata) begin
        fails++;
        $display("FAIL %s regRdata actual=%h expected=%h", expTag, regRdata, expRdata);
      end
      checks++;
      if (txIrq !== expIrq) begin
        fails++;
        $display("FAIL R6 txIrq actual=%b expected=%b", txIrq, expIrq);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    timeNow = timeNow + 64'd7;
  endtask

  task automatic idle();
    rxStrobe = 0; txStrobe = 0; regRead = 0; regWrite = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    compareOn = 1'b1;
    // R1: reset state at the ports
    check("R1 rdata after reset", regRdata, 32'd0);
    check("R1 txIrq after reset", {31'd0, txIrq}, 32'd0);
    regRead = 1; regAddr = 5'd0;
    tick();
    check("R1 control word", regRdata, 32'h0001_0000);
    regAddr = 5'd1;
    tick();
    check("R1 status word", regRdata, 32'd0);
    idle();
    // R2/R4: capture into slot 2, lower read keeps lock, upper read frees it
    rxStrobe = 1; rxSlot = 2'd2;
    tick();
    idle(); regRead = 1; regAddr = 5'd8;
    tick();
    regAddr = 5'd1;
    tick();
    check("R4 lock kept after lower read", regRdata & 32'h4, 32'h4);
    regAddr = 5'd9;
    tick();
    regAddr = 5'd1;
    tick();
    check("R4 unlocked after upper read", regRdata & 32'h4, 32'h0);
    idle();
    // R3: double strobe on slot 1 drops the second
    rxStrobe = 1; rxSlot = 2'd1;
    tick(); tick();
    idle(); regRead = 1; regAddr = 5'd2;
    tick();
    check("R3 dropped count", regRdata, 32'd1);
    idle();
    // R6/R5: enable interrupt and capture on transmit
    regWrite = 1; regAddr = 5'd0; regWdata = 32'h0003_0001;
    tick();
    idle(); txStrobe = 1;
    tick();
    idle();
    check("R6 irq raised", {31'd0, txIrq}, 32'd1);
    // R7: toggle pin with both-edge mode
    auxPin = 1;
    repeat (5) tick();
    regRead = 1; regAddr = 5'd1;
    tick();
    check("R7 pin slot locked", regRdata & 32'h20, 32'h20);
    idle();
    // mixed stimulus compared against the model every clock
    for (int n = 0; n < 4000; n++) begin
      rxStrobe = ($urandom % 4) == 0;
      rxSlot   = 2'($urandom % 4);
      txStrobe = ($urandom % 6) == 0;
      if (($urandom % 5) == 0) auxPin = ~auxPin;
      regRead  = ($urandom % 3) == 0;
      regAddr  = 5'($urandom % 18);
      regWrite = ($urandom % 40) == 0;
      regWdata = $urandom;
      timeNow  = timeNow + 64'($urandom % 13);
      @(negedge clk);
    end
    idle();
    tick(); tick();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule